// File: doc/BRIEF.md
# Random-Number Generator Control and Recovery

This block is the register-mapped control and status front end of a hardware random-number generator. Software reaches it over a plain 32-bit register bus with address, write strobe, read strobe and data. A raw entropy bit arrives on an input port. At each tick of a prescaled sampling clock the bit is folded into a 32-bit linear feedback shift register, which stands in for a conditioner. After 32 such samples a word is posted for reading and a data-ready indication is raised.

Configuration is protected by a conditioning-reset handshake. The entropy-source fields of the control register take effect only when they are written in the same access that sets the conditioning-reset bit. Clearing that bit starts a fixed internal reset, during which the bit still reads back as one. A seed-error input stops generation and raises two indications: a live status bit and a sticky flag. Recovery is then either automatic, once the error input falls, or driven by software through the conditioning reset. A clock-error input is reported the same way when its detection is enabled. A lock bit freezes the configuration until the next block reset.

Top module: `rng_ctrl`

## Requirements
- R1: After reset, the control register (offset 0x00) reads 0x00F00D00, the status register (0x04) reads 0, the noise-source register (0x0C) reads 0x2B5BB, the health register (0x10) reads 0x969D, the data register (0x08) reads 0, and `data_ready` and `seed_alarm` are low.
- R2: The configuration fields of the control register (bit 5 clock-check enable, and bits [25:8], which hold the prescale exponent in bits [19:16]) change only in a control write that also has bit 30 set. Any other control write leaves them unchanged.
- R3: Writing control bit 30 as 1 makes it read 1. A later control write with bit 30 at 0 keeps it reading 1 for 16 more clock cycles. After that it reads 0, and the completion restarts collection from the seed.
- R4: A control write with bit 31 set locks the block. While locked, bit 31 stays set and the configuration fields ignore every write, even one with bit 30 set. The enable bit (bit 2) stays writable.
- R5: While `seed_err_inj` is high, status bit 6 (seed flag, also driven on `seed_alarm`) and status bit 2 (seed live) are set and no new word becomes ready.
- R6: With control bit 3 (automatic recovery) set, status bit 2 clears in the cycle after `seed_err_inj` falls. Bit 6 stays set. Collection restarts from the seed.
- R7: With control bit 3 clear, status bit 2 stays set until a conditioning reset completes. Generation then resumes from the seed.
- R8: Writing 0 to status bit 5 or bit 6 clears that flag. Writing 1 leaves it unchanged. Status bits 0, 1 and 2 are not writable.
- R9: A seed error that arrives while a word is waiting makes the next data read return 0.
- R10: The mixer starts from state 0x00000001. At each sample, with state s and noise bit n, the new state is {s[30:0], s[31]^s[21]^s[1]^s[0]^n}. The posted word is the state after 32 samples. A data read while status bit 0 is set returns that word and clears bit 0. A data read while bit 0 is clear returns 0.
- R11: With prescale exponent d, `data_ready` rises exactly 32·2^d clock cycles after the edge that accepts the enabling write, from a freshly reset collector.
- R12: With control bit 5 set, a high `clk_err_inj` sets status bit 1 (live) and bit 5 (sticky). Bit 1 follows the input one cycle late. With control bit 5 clear the input is ignored.
- R13: The noise-source register keeps only its low 18 bits. The health register keeps all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| noise_bit | input | 1 | Raw entropy bit |
| seed_err_inj | input | 1 | Seed-error indication, active high |
| clk_err_inj | input | 1 | Clock-error indication, active high |
| data_ready | output | 1 | A word is waiting in the data register |
| seed_alarm | output | 1 | Sticky seed-error flag |

## Verification
Read data is registered, so each read is sampled on the falling edge after the edge that takes the strobe. The word-ready time is counted in falling edges after the enabling write, and must equal 32·2^d, with no slack allowed. Conditioning-reset completion is due 16 cycles after the clearing write: the bench reads bit 30 once straight away, expecting 1, and once after 20 cycles, expecting 0. Live error bits are read while the error input is held, then again a few cycles after it drops. Each status read that must show the seed or clock state is made before the next word could become ready.

// File: rtl/rng_ctrl_pkg.sv
package rng_ctrl_pkg;
   // register word indices (byte offset / 4)
   localparam int unsigned IDX_CTRL   = 0;
   localparam int unsigned IDX_STAT   = 1;
   localparam int unsigned IDX_DATA   = 2;
   localparam int unsigned IDX_NOISE  = 3;
   localparam int unsigned IDX_HEALTH = 4;

   // control register fields
   localparam int unsigned C_EN     = 2;
   localparam int unsigned C_AUTO   = 3;
   localparam int unsigned C_CLKCHK = 5;
   localparam int unsigned C_CFG_LO = 8;
   localparam int unsigned C_CFG_HI = 25;
   localparam int unsigned C_DIV_LO = 16;
   localparam int unsigned C_CRST   = 30;
   localparam int unsigned C_LOCK   = 31;

   // status register fields
   localparam int unsigned S_RDY   = 0;
   localparam int unsigned S_CLK   = 1;
   localparam int unsigned S_SEED  = 2;
   localparam int unsigned S_CLKF  = 5;
   localparam int unsigned S_SEEDF = 6;

   typedef enum logic [1:0] {
      CRST_IDLE = 2'd0,
      CRST_HELD = 2'd1,
      CRST_RUN  = 2'd2
   } crst_state_t;
endpackage

// File: rtl/rng_prescale.sv
module rng_prescale #(
   parameter int DIV_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   localparam int CNT_W = (1 << DIV_W) - 1;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] mask;

   initial begin
      assert (DIV_W >= 1 && DIV_W <= 5) else $error("rng_prescale: DIV_W out of range");
   end

   assign mask = ~({CNT_W{1'b1}} << div);
   assign tick = run && (cnt == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else if (!run || tick) cnt <= '0;
      else cnt <= cnt + 1'b1;
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt <= mask)) else $error("prescale counter past limit"); // R11
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt == '0)) else $error("prescale counter moved while idle"); // R11
endmodule

// File: rtl/rng_condrst.sv
module rng_condrst import rng_ctrl_pkg::*; #(
   parameter int RST_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cr_wr,
   input  logic crst_bit,
   output logic busy,
   output logic done
);
   localparam int CNT_W = (RST_CYCLES > 2) ? $clog2(RST_CYCLES) : 1;

   crst_state_t      state;
   logic [CNT_W-1:0] cnt;
   logic             req_set;
   logic             req_clr;

   initial begin
      assert (RST_CYCLES >= 2) else $error("rng_condrst: RST_CYCLES too small");
   end

   assign req_set = cr_wr && crst_bit;
   assign req_clr = cr_wr && !crst_bit;
   assign busy    = (state != CRST_IDLE);
   assign done    = (state == CRST_RUN) && (cnt == '0) && !req_set;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= CRST_IDLE;
         cnt   <= '0;
      end else begin
         case (state)
            CRST_IDLE: if (req_set) state <= CRST_HELD;
            CRST_HELD: if (req_clr) begin
               state <= CRST_RUN;
               cnt   <= CNT_W'(RST_CYCLES - 1);
            end
            CRST_RUN: begin
               if (req_set) state <= CRST_HELD;
               else if (cnt == '0) state <= CRST_IDLE;
               else cnt <= cnt - 1'b1;
            end
            default: state <= CRST_IDLE;
         endcase
      end
   end

   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy) else $error("busy after reset completion"); // R3
   AST_HELD_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (state == CRST_HELD) && !cr_wr |=> busy) else $error("held reset dropped"); // R3
   AST_DONE_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy)) else $error("completion without running reset"); // R3
endmodule

// File: rtl/rng_mixer.sv
module rng_mixer #(
   parameter int          W    = 32,
   parameter logic [W-1:0] TAPS = 32'h8020_0003,
   parameter logic [W-1:0] SEED = 32'h0000_0001
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         noise,
   input  logic         flush,
   input  logic         poison,
   input  logic         take,
   output logic         ready,
   output logic [W-1:0] word
);
   localparam int BC_W = $clog2(W);
   localparam logic [BC_W-1:0] LAST = BC_W'(W - 1);

   logic [W-1:0]    state;
   logic [W-1:0]    nxt;
   logic [BC_W-1:0] bcnt;

   initial begin
      assert (W >= 8) else $error("rng_mixer: W too small");
      assert (SEED != '0) else $error("rng_mixer: zero seed");
   end

   assign nxt = {state[W-2:0], (^(state & TAPS)) ^ noise};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SEED;
         bcnt  <= '0;
         ready <= 1'b0;
         word  <= '0;
      end else if (flush) begin
         state <= SEED;
         bcnt  <= '0;
         ready <= 1'b0;
         word  <= '0;
      end else begin
         if (take) ready <= 1'b0;
         if (tick) begin
            state <= nxt;
            if (bcnt == LAST) begin
               bcnt  <= '0;
               word  <= nxt;
               ready <= 1'b1;
            end else begin
               bcnt <= bcnt + 1'b1;
            end
         end
         if (poison) word <= '0;
      end
   end

   AST_RDY_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(tick)) else $error("ready without sample"); // R11
   AST_POISON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      poison && !flush |=> (word == '0)) else $error("word survived seed error"); // R9
   AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      take && !tick |=> !ready) else $error("ready survived read"); // R10
endmodule

// File: rtl/rng_ctrl.sv
module rng_ctrl import rng_ctrl_pkg::*; #(
   parameter int          ADDR_W       = 5,
   parameter int          DIV_W        = 4,
   parameter int          RST_CYCLES   = 16,
   parameter int          AUTO_RECOVER = 1,
   parameter int          NOISE_W      = 18,
   parameter logic [31:0] SEED         = 32'h0000_0001,
   parameter logic [31:0] TAPS         = 32'h8020_0003,
   parameter logic [31:0] CTRL_DEF     = 32'h00F0_0D00,
   parameter logic [31:0] NOISE_DEF    = 32'h0002_B5BB,
   parameter logic [31:0] HEALTH_DEF   = 32'h0000_969D
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              noise_bit,
   input  logic              seed_err_inj,
   input  logic              clk_err_inj,
   output logic              data_ready,
   output logic              seed_alarm
);
   localparam int IDX_W  = ADDR_W - 2;
   localparam int CFG_W  = C_CFG_HI - C_CFG_LO + 1;
   localparam int DIV_AT = C_DIV_LO - C_CFG_LO;

   initial begin
      assert (ADDR_W >= 5) else $error("rng_ctrl: ADDR_W too small for map");
      assert (NOISE_W >= 1 && NOISE_W <= 32) else $error("rng_ctrl: NOISE_W out of range");
      assert (DIV_AT + DIV_W <= CFG_W) else $error("rng_ctrl: divider field overflows config");
   end

   logic [IDX_W-1:0]   idx;
   logic               acc_ok;
   logic               wr_cr, wr_sr, wr_ns, wr_ht, rd_dr;
   logic               en, ced, lock, auto_r;
   logic [CFG_W-1:0]   cfg;
   logic               seed_live, seed_flag, clk_live, clk_flag;
   logic [NOISE_W-1:0] nscr;
   logic [31:0]        htcr;
   logic               crst_busy, crst_done;
   logic               rec_auto, flush, run, tick, clk_hit;
   logic               mix_ready;
   logic [31:0]        mix_word;
   logic [31:0]        cr_view, sr_view, rd_mux;

   assign idx    = bus_addr[ADDR_W-1:2];
   assign acc_ok = (bus_addr[1:0] == 2'b00);
   assign wr_cr  = bus_wr && acc_ok && (idx == IDX_W'(IDX_CTRL));
   assign wr_sr  = bus_wr && acc_ok && (idx == IDX_W'(IDX_STAT));
   assign wr_ns  = bus_wr && acc_ok && (idx == IDX_W'(IDX_NOISE));
   assign wr_ht  = bus_wr && acc_ok && (idx == IDX_W'(IDX_HEALTH));
   assign rd_dr  = bus_rd && acc_ok && (idx == IDX_W'(IDX_DATA));

   // configuration, lock and enable
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg  <= CTRL_DEF[C_CFG_HI:C_CFG_LO];
         ced  <= CTRL_DEF[C_CLKCHK];
         en   <= CTRL_DEF[C_EN];
         lock <= CTRL_DEF[C_LOCK];
      end else if (wr_cr) begin
         en <= bus_wdata[C_EN];
         if (bus_wdata[C_LOCK]) lock <= 1'b1;
         if (bus_wdata[C_CRST] && !lock) begin
            cfg <= bus_wdata[C_CFG_HI:C_CFG_LO];
            ced <= bus_wdata[C_CLKCHK];
         end
      end
   end

   generate
      if (AUTO_RECOVER != 0) begin : g_auto
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) auto_r <= CTRL_DEF[C_AUTO];
            else if (wr_cr) auto_r <= bus_wdata[C_AUTO];
         end
      end else begin : g_noauto
         assign auto_r = 1'b0;
      end
   endgenerate

   // auxiliary configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nscr <= NOISE_DEF[NOISE_W-1:0];
         htcr <= HEALTH_DEF;
      end else begin
         if (wr_ns) nscr <= bus_wdata[NOISE_W-1:0];
         if (wr_ht) htcr <= bus_wdata;
      end
   end

   rng_condrst #(.RST_CYCLES(RST_CYCLES)) u_crst (
      .clk      (clk),
      .rst_n    (rst_n),
      .cr_wr    (wr_cr),
      .crst_bit (bus_wdata[C_CRST]),
      .busy     (crst_busy),
      .done     (crst_done)
   );

   // seed and clock error tracking
   assign rec_auto = auto_r && seed_live && !seed_err_inj;
   assign flush    = crst_done || rec_auto;
   assign clk_hit  = clk_err_inj && ced;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seed_live <= 1'b0;
         seed_flag <= 1'b0;
         clk_live  <= 1'b0;
         clk_flag  <= 1'b0;
      end else begin
         if (seed_err_inj) seed_live <= 1'b1;
         else if (flush) seed_live <= 1'b0;

         if (seed_err_inj) seed_flag <= 1'b1;
         else if (wr_sr && !bus_wdata[S_SEEDF]) seed_flag <= 1'b0;

         clk_live <= clk_hit;
         if (clk_hit) clk_flag <= 1'b1;
         else if (wr_sr && !bus_wdata[S_CLKF]) clk_flag <= 1'b0;
      end
   end

   assign run = en && !seed_live && !crst_busy && !mix_ready;

   rng_prescale #(.DIV_W(DIV_W)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .div   (cfg[DIV_AT +: DIV_W]),
      .tick  (tick)
   );

   rng_mixer #(.W(32), .TAPS(TAPS), .SEED(SEED)) u_mix (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .noise  (noise_bit),
      .flush  (flush),
      .poison (seed_err_inj),
      .take   (rd_dr),
      .ready  (mix_ready),
      .word   (mix_word)
   );

   // register views and read port
   always_comb begin
      cr_view                   = '0;
      cr_view[C_LOCK]           = lock;
      cr_view[C_CRST]           = crst_busy;
      cr_view[C_CFG_HI:C_CFG_LO] = cfg;
      cr_view[C_CLKCHK]         = ced;
      cr_view[C_AUTO]           = auto_r;
      cr_view[C_EN]             = en;
      sr_view                   = '0;
      sr_view[S_SEEDF]          = seed_flag;
      sr_view[S_CLKF]           = clk_flag;
      sr_view[S_SEED]           = seed_live;
      sr_view[S_CLK]            = clk_live;
      sr_view[S_RDY]            = mix_ready;
   end

   always_comb begin
      rd_mux = '0;
      if (acc_ok) begin
         case (idx)
            IDX_W'(IDX_CTRL):   rd_mux = cr_view;
            IDX_W'(IDX_STAT):   rd_mux = sr_view;
            IDX_W'(IDX_DATA):   rd_mux = mix_ready ? mix_word : 32'h0;
            IDX_W'(IDX_NOISE):  rd_mux = 32'(nscr);
            IDX_W'(IDX_HEALTH): rd_mux = htcr;
            default:            rd_mux = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
   end

   assign data_ready = mix_ready;
   assign seed_alarm = seed_flag;

   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_cr && bus_wdata[C_CRST] && !lock) |=> $stable(cfg)) else $error("config moved without reset write"); // R2
   AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> lock) else $error("lock dropped"); // R4
   AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> ($stable(cfg) && $stable(ced))) else $error("locked config changed"); // R4
   AST_SEED_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      seed_live |-> !tick) else $error("sampling during seed error"); // R5
   AST_SEED_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(seed_live) |-> seed_flag) else $error("live seed error without flag"); // R5
   AST_AUTO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      auto_r && seed_live && !seed_err_inj |=> !seed_live) else $error("automatic recovery missed"); // R6
   AST_SW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      seed_live && !auto_r && !crst_done |=> seed_live) else $error("seed status cleared without reset"); // R7
   AST_CLK_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      !ced |=> !clk_live) else $error("clock error seen while disabled"); // R12
endmodule

// File: tb/rng_ctrl_tb.sv
module rng_ctrl_tb;
   localparam logic [4:0]  A_CTRL = 5'h00, A_STAT = 5'h04, A_DATA = 5'h08,
                           A_NOISE = 5'h0C, A_HEALTH = 5'h10;
   localparam logic [31:0] EN = 32'h4, AUTO = 32'h8, CLKCHK = 32'h20,
                           CRST = 32'h4000_0000, LOCK = 32'h8000_0000;
   localparam logic [31:0] BASE0 = 32'h00F0_0D00;
   localparam logic [31:0] SEED  = 32'h1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        noise_bit = 1'b0, seed_err_inj = 1'b0, clk_err_inj = 1'b0;
   logic        data_ready, seed_alarm;

   int n_cmp = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   rng_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .noise_bit(noise_bit),
      .seed_err_inj(seed_err_inj), .clk_err_inj(clk_err_inj),
      .data_ready(data_ready), .seed_alarm(seed_alarm)
   );

   function automatic logic [31:0] step32(input logic [31:0] s, input logic n);
      logic [31:0] v = s;
      for (int i = 0; i < 32; i++) v = {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0] ^ n};
      return v;
   endfunction

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic bwrite(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bread(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic wait_ready();
      while (!data_ready) @(negedge clk);
   endtask

   task automatic crst_cfg(input logic [31:0] cfgw);
      bwrite(A_CTRL, cfgw | CRST);
      bwrite(A_CTRL, cfgw);
      repeat (20) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] r, model, expw, base;
      int          n, d, seed_v;
      seed_v = $urandom(32'd4242);
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 data_ready", 32'(data_ready), 0);
      chk("R1 seed_alarm", 32'(seed_alarm), 0);
      bread(A_CTRL, r);   chk("R1 ctrl", r, 32'h00F0_0D00);
      bread(A_STAT, r);   chk("R1 stat", r, 0);
      bread(A_NOISE, r);  chk("R1 noise", r, 32'h2B5BB);
      bread(A_HEALTH, r); chk("R1 health", r, 32'h969D);
      bread(A_DATA, r);   chk("R1 data", r, 0);

      // R2 / R3 config latching and reset handshake
      bwrite(A_CTRL, 32'h03FF_FF00);
      bread(A_CTRL, r);   chk("R2 plain write ignored", r, 32'h00F0_0D00);
      bwrite(A_CTRL, 32'h00A5_5A00 | CRST);
      bread(A_CTRL, r);   chk("R2 latch with reset bit", r, 32'h40A5_5A00);
      bwrite(A_CTRL, 32'h00A5_5A00);
      bread(A_CTRL, r);   chk("R3 busy after clear", r, 32'h40A5_5A00);
      repeat (20) @(negedge clk);
      bread(A_CTRL, r);   chk("R3 reset done", r, 32'h00A5_5A00);

      // R10 / R11 random words under random prescale and noise
      for (int it = 0; it < 6; it++) begin
         d = $urandom % 3;
         noise_bit = 1'($urandom % 2);
         base = (BASE0 & ~32'h000F_0000) | (32'(d) << 16);
         crst_cfg(base);
         model = SEED;
         bwrite(A_CTRL, base | EN);
         n = 0;
         while (!data_ready) begin @(negedge clk); n++; end
         chk("R11 ready delay", 32'(n), 32'(32 << d));
         bread(A_DATA, r);
         expw = step32(model, noise_bit); model = expw;
         chk("R10 first word", r, expw);
         chk("R10 ready cleared", 32'(data_ready), 0);
         bread(A_DATA, r);   chk("R10 empty read", r, 0);
         wait_ready();
         bread(A_DATA, r);
         expw = step32(model, noise_bit); model = expw;
         chk("R10 second word", r, expw);
         bwrite(A_CTRL, base);
      end

      // R9 / R5 / R7 late seed error and software recovery
      noise_bit = 1'b1;
      crst_cfg(BASE0);
      bwrite(A_CTRL, BASE0 | EN);
      wait_ready();
      @(negedge clk); seed_err_inj = 1'b1;
      @(negedge clk); seed_err_inj = 1'b0;
      bread(A_DATA, r);   chk("R9 zero after late seed error", r, 0);
      bread(A_STAT, r);   chk("R5 seed bits", r, 32'h44);
      repeat (50) @(negedge clk);
      chk("R5 generation stopped", 32'(data_ready), 0);
      chk("R5 seed_alarm", 32'(seed_alarm), 1);
      bread(A_STAT, r);   chk("R7 live stays set", r, 32'h44);
      bwrite(A_CTRL, BASE0 | EN | CRST);
      bwrite(A_CTRL, BASE0 | EN);
      repeat (20) @(negedge clk);
      bread(A_STAT, r);   chk("R7 live cleared by reset", r, 32'h40);
      bwrite(A_STAT, 32'hFFFF_FFFF);
      bread(A_STAT, r);   chk("R8 write ones keeps flag", r, 32'h40);
      bwrite(A_STAT, 32'h0);
      bread(A_STAT, r);   chk("R8 write zero clears", r, 32'h0);
      wait_ready();
      bread(A_DATA, r);   chk("R7 resumes from seed", r, step32(SEED, 1'b1));

      // R6 automatic recovery
      bwrite(A_CTRL, BASE0 | EN | AUTO);
      @(negedge clk); seed_err_inj = 1'b1;
      bread(A_STAT, r);   chk("R6 held error", r, 32'h44);
      seed_err_inj = 1'b0;
      repeat (3) @(negedge clk);
      bread(A_STAT, r);   chk("R6 auto cleared", r, 32'h40);
      wait_ready();
      bread(A_DATA, r);   chk("R6 restart from seed", r, step32(SEED, 1'b1));
      bwrite(A_STAT, 32'h0);

      // R12 clock error
      crst_cfg(BASE0 | CLKCHK);
      clk_err_inj = 1'b1;
      repeat (2) @(negedge clk);
      bread(A_STAT, r);   chk("R12 clock error live", r, 32'h22);
      clk_err_inj = 1'b0;
      repeat (2) @(negedge clk);
      bread(A_STAT, r);   chk("R12 clock flag sticky", r, 32'h20);
      bwrite(A_STAT, 32'h0);
      crst_cfg(BASE0);
      clk_err_inj = 1'b1;
      repeat (2) @(negedge clk);
      bread(A_STAT, r);   chk("R12 disabled ignored", r, 32'h0);
      clk_err_inj = 1'b0;

      // R13 auxiliary registers
      bwrite(A_NOISE, 32'hFFFF_FFFF);
      bread(A_NOISE, r);  chk("R13 noise width", r, 32'h3FFFF);
      bwrite(A_HEALTH, 32'hCAFE_1234);
      bread(A_HEALTH, r); chk("R13 health", r, 32'hCAFE_1234);

      // R4 lock
      bwrite(A_CTRL, BASE0 | LOCK);
      bread(A_CTRL, r);   chk("R4 lock set", r, 32'h80F0_0D00);
      bwrite(A_CTRL, 32'h03FF_FF24 | CRST);
      bread(A_CTRL, r);   chk("R4 config frozen", r, 32'hC0F0_0D04);
      bwrite(A_CTRL, 32'h0);
      repeat (20) @(negedge clk);
      bread(A_CTRL, r);   chk("R4 lock stays", r, 32'h80F0_0D00);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule